// File: doc/BRIEF.md
# CAN Message Queue Controller

This block keeps the bookkeeping of one message queue inside a CAN controller. It tracks where the next message goes in, where the next one comes out, and how many are stored. It also turns a host-visible control word into occupancy flags, a send request, an abort pulse and gated interrupt lines. The message storage itself is not part of the block. The block computes the byte offset of the slot that the host side and the protocol engine each work on, so that an external RAM can be addressed. This offset uses the configured payload width plus a fixed header.

One control bit chooses the role. As a transmit queue, the host loads a slot and bumps the head, and the protocol engine drains from the tail. As a receive queue, the engine fills at the head and the host releases slots by bumping the tail. A send request starts transmission and clears itself when the queue drains. Software cancels it by writing it back to zero. A remote frame can raise the request when auto-reply is enabled. A retry policy limits how many failed attempts are tolerated. A self-clearing reset bit empties the queue.

Control word layout (one write updates every writable field): [4:0] depth minus one, [7:5] payload code, [12:8] priority, [14:13] retry code, [15] direction (1 = transmit), [16] remote auto-reply enable, [17] timestamp enable, [18] exhaust IE, [19] overflow IE, [20] level IE, [21] half IE, [22] room IE, [23] queue reset, [24] send request, [25] increment strobe (reads 0).

Top module: `can_msg_queue`

## Requirements
- R1: The queue holds depth field + 1 messages. The count never exceeds that value. `full_o` is high exactly when the count equals it, and `empty_o` is high exactly when the count is 0.
- R2: Payload code 0..7 gives 8, 12, 16, 20, 24, 32, 48 or 64 bytes on `payload_bytes_o`. Each slot offset equals the slot index times (payload bytes + 8).
- R3: Depth, payload code and timestamp enable change only on a write while `mode_i` is 3'b100; in other modes they keep their value. All other fields update on every write. A change of depth or payload code empties the queue.
- R4: In transmit role, an increment strobe advances the head and raises the count, and is ignored when the queue is full. `sent_i` advances the tail and lowers the count. `host_ofs_o` follows the head and `eng_ofs_o` follows the tail.
- R5: In receive role, `rx_msg_i` advances the head. An increment strobe advances the tail and is ignored when the queue is empty. `host_ofs_o` follows the tail and `eng_ofs_o` follows the head.
- R6: The reset bit (bit 23) reads 1 after `rst_ni` and after a write of 1. It reads 0 one cycle later, and by then head, tail, count, send request and sticky flags are 0.
- R7: In transmit role, writing bit 24 as 1 sets the send request and `tx_pending_o` is high while the queue is non-empty. The request clears when a `sent_i` leaves the queue empty.
- R8: In transmit role, a write with bit 24 at 0 while the request is set clears it and pulses `abort_o` high for exactly one cycle. In receive role, bit 24 reads 0 and `tx_pending_o` and `abort_o` stay low whatever is written.
- R9: In transmit role with bit 16 set, `rtr_rx_i` sets the send request. With bit 16 clear it leaves the request unchanged.
- R10: The retry policy applies when `retry_glb_en_i` is high. Code 00 exhausts on the first `tx_fail_i` while requesting. Code 01 exhausts on the fourth. Codes 10 and 11 never exhaust, and neither does any code when `retry_glb_en_i` is low. Exhaustion clears the request and sets a sticky flag seen on `irq_exhaust_o` when bit 18 is set. A new request write clears the flag.
- R11: The level, half and room interrupts depend on the role. In transmit role they mean empty, half empty and not full. In receive role they mean full, half full and not empty. Each is ANDed with its enable (bits 20, 21, 22), and `irq_o` is the OR of all five interrupts.
- R12: In receive role, `rx_msg_i` on a full queue leaves the count unchanged. It sets a sticky overflow flag, seen on `irq_ovf_o` when bit 19 is set and cleared by a host increment or a queue reset.
- R13: Half full means count >= ceil(depth/2). Half empty means count <= floor(depth/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Controller operating mode; 3'b100 is configuration |
| retry_glb_en_i | input | 1 | Global enable of the retry limit |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 26 | Control word write data |
| rd_data_o | output | 26 | Control word read-back |
| sent_i | input | 1 | Engine finished sending one message |
| tx_fail_i | input | 1 | Engine transmit attempt failed |
| rx_msg_i | input | 1 | Engine received one message |
| rtr_rx_i | input | 1 | Engine received a remote frame for this queue |
| head_o | output | 5 | Head index |
| tail_o | output | 5 | Tail index |
| count_o | output | 6 | Stored message count |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| tx_pending_o | output | 1 | Transmit request toward the engine |
| abort_o | output | 1 | One-cycle abort request |
| host_ofs_o | output | 12 | Byte offset of the host-side slot |
| eng_ofs_o | output | 12 | Byte offset of the engine-side slot |
| payload_bytes_o | output | 7 | Decoded payload bytes per message |
| prio_o | output | 5 | Transmit priority field |
| irq_exhaust_o | output | 1 | Retries exhausted, gated |
| irq_ovf_o | output | 1 | Receive overflow, gated |
| irq_lvl_o | output | 1 | Empty (transmit) / full (receive), gated |
| irq_half_o | output | 1 | Half empty (transmit) / half full (receive), gated |
| irq_room_o | output | 1 | Not full (transmit) / not empty (receive), gated |
| irq_o | output | 1 | OR of the gated interrupts |

## Verification
The assertions assume that a host write and a protocol-engine event never land in the same cycle when one of them changes the send request. They also assume that the engine raises `sent_i` only for a queue that holds a message. The full-queue check also assumes that the increment write repeats the current direction and geometry. The directed stimulus keeps to these assumptions. It issues each write and each event pulse in a cycle of its own. Every increment or request write repeats the current direction, geometry and enables, so no write changes the role or empties the queue by accident.

// File: rtl/can_mq_pkg.sv
package can_mq_pkg;
  localparam int unsigned DEPTH_W = 5;

  // control word field positions
  localparam int unsigned F_DEPTH = 0;
  localparam int unsigned F_PL    = 5;
  localparam int unsigned F_PRIO  = 8;
  localparam int unsigned F_RETRY = 13;
  localparam int unsigned F_DIR   = 15;
  localparam int unsigned F_RTR   = 16;
  localparam int unsigned F_TS    = 17;
  localparam int unsigned F_IE    = 18;
  localparam int unsigned F_RST   = 23;
  localparam int unsigned F_REQ   = 24;
  localparam int unsigned F_INC   = 25;
  localparam int unsigned REG_W   = F_INC + 1;

  localparam logic [2:0] CFG_MODE = 3'b100;

  typedef struct packed {
    logic [DEPTH_W-1:0] depth_m1;
    logic [2:0]         pl_code;
    logic [4:0]         prio;
    logic [1:0]         retry_code;
    logic               dir_tx;
    logic               rtr_en;
    logic               ts_en;
    logic [4:0]         ie;  // {room, half, lvl, ovf, exhaust}
  } mq_cfg_t;

  function automatic logic [6:0] pl_bytes(input logic [2:0] code);
    case (code)
      3'd0: pl_bytes = 7'd8;
      3'd1: pl_bytes = 7'd12;
      3'd2: pl_bytes = 7'd16;
      3'd3: pl_bytes = 7'd20;
      3'd4: pl_bytes = 7'd24;
      3'd5: pl_bytes = 7'd32;
      3'd6: pl_bytes = 7'd48;
      default: pl_bytes = 7'd64;
    endcase
  endfunction
endpackage

// File: rtl/mq_cfg_regs.sv
module mq_cfg_regs
  import can_mq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic             wr_en_i,
  input  logic [F_RST:0]   wr_data_i,
  output mq_cfg_t          cfg_o,
  output logic             freset_o,
  output logic             geom_chg_o
);
  mq_cfg_t cfg_q;
  logic    freset_q;

  logic [DEPTH_W-1:0] w_depth;
  logic [2:0]         w_pl;

  assign w_depth = wr_data_i[F_DEPTH +: DEPTH_W];
  assign w_pl    = wr_data_i[F_PL +: 3];

  // geometry change empties the queue in the same edge
  assign geom_chg_o = wr_en_i && cfg_mode_i &&
                      ((w_depth != cfg_q.depth_m1) || (w_pl != cfg_q.pl_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q            <= '0;
      cfg_q.retry_code <= 2'b11;
      freset_q         <= 1'b1;
    end else begin
      if (freset_q) freset_q <= 1'b0;
      if (wr_en_i) begin
        cfg_q.prio       <= wr_data_i[F_PRIO +: 5];
        cfg_q.retry_code <= wr_data_i[F_RETRY +: 2];
        cfg_q.dir_tx     <= wr_data_i[F_DIR];
        cfg_q.rtr_en     <= wr_data_i[F_RTR];
        cfg_q.ie         <= wr_data_i[F_IE +: 5];
        if (cfg_mode_i) begin
          cfg_q.depth_m1 <= w_depth;
          cfg_q.pl_code  <= w_pl;
          cfg_q.ts_en    <= wr_data_i[F_TS];
        end
        if (wr_data_i[F_RST]) freset_q <= 1'b1;
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign freset_o = freset_q;
endmodule

// File: rtl/mq_ptr_track.sv
module mq_ptr_track #(
  parameter int unsigned IDX_W = 5,
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] depth_m1_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p,
                                                input logic [IDX_W-1:0] lim);
    wrap_inc = (p == lim) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) head_q <= wrap_inc(head_q, depth_m1_i);
      if (pop_i)  tail_q <= wrap_inc(tail_q, depth_m1_i);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (CNT_W'(depth_m1_i) + CNT_W'(1)));
endmodule

// File: rtl/mq_tx_ctrl.sv
module mq_tx_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       dir_tx_i,
  input  logic       wr_en_i,
  input  logic       req_wr_i,
  input  logic       rtr_ev_i,
  input  logic       drained_i,
  input  logic       sent_i,
  input  logic       fail_i,
  input  logic       retry_en_i,
  input  logic [1:0] retry_code_i,
  output logic       send_req_o,
  output logic       abort_o,
  output logic       exhaust_o
);
  logic       req_q, abort_q, exh_q;
  logic [1:0] fails_q;
  logic       limited;
  logic [1:0] fail_lim;

  assign limited  = retry_en_i && !retry_code_i[1];
  assign fail_lim = retry_code_i[0] ? 2'd3 : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      abort_q <= 1'b0;
      exh_q   <= 1'b0;
      fails_q <= '0;
    end else begin
      abort_q <= 1'b0;
      if (clr_i || !dir_tx_i) begin
        req_q   <= 1'b0;
        exh_q   <= 1'b0;
        fails_q <= '0;
      end else if (wr_en_i) begin
        if (req_wr_i) begin
          req_q   <= 1'b1;
          exh_q   <= 1'b0;
          fails_q <= '0;
        end else if (req_q) begin
          req_q   <= 1'b0;
          abort_q <= 1'b1;
        end
      end else if (rtr_ev_i) begin
        req_q <= 1'b1;
      end else if (req_q && drained_i) begin
        req_q   <= 1'b0;
        fails_q <= '0;
      end else if (req_q && fail_i) begin
        if (limited) begin
          if (fails_q == fail_lim) begin
            exh_q   <= 1'b1;
            req_q   <= 1'b0;
            fails_q <= '0;
          end else begin
            fails_q <= fails_q + 1'b1;
          end
        end
      end else if (sent_i) begin
        fails_q <= '0;
      end
    end
  end

  assign send_req_o = req_q;
  assign abort_o    = abort_q;
  assign exhaust_o  = exh_q;
endmodule

// File: rtl/can_msg_queue.sv
module can_msg_queue
  import can_mq_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 8,
  parameter int unsigned OFS_W     = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic               retry_glb_en_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               sent_i,
  input  logic               tx_fail_i,
  input  logic               rx_msg_i,
  input  logic               rtr_rx_i,
  output logic [DEPTH_W-1:0] head_o,
  output logic [DEPTH_W-1:0] tail_o,
  output logic [DEPTH_W:0]   count_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               tx_pending_o,
  output logic               abort_o,
  output logic [OFS_W-1:0]   host_ofs_o,
  output logic [OFS_W-1:0]   eng_ofs_o,
  output logic [6:0]         payload_bytes_o,
  output logic [4:0]         prio_o,
  output logic               irq_exhaust_o,
  output logic               irq_ovf_o,
  output logic               irq_lvl_o,
  output logic               irq_half_o,
  output logic               irq_room_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = DEPTH_W;
  localparam int unsigned CNT_W = DEPTH_W + 1;

  mq_cfg_t          cfg;
  logic             freset, geom_chg, clr;
  logic             incr_stb, tx, push, pop, drained;
  logic             send_req, exhaust;
  logic             ovf_q;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt, depth;
  logic             empty, full;
  logic             lvl_ev, half_ev, room_ev;
  logic [6:0]       pay_b;

  mq_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (mode_i == CFG_MODE),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i[F_RST:0]),
    .cfg_o      (cfg),
    .freset_o   (freset),
    .geom_chg_o (geom_chg)
  );

  assign clr      = freset | geom_chg;
  assign tx       = cfg.dir_tx;
  assign incr_stb = wr_en_i & wr_data_i[F_INC] & ~freset;

  // role-dependent ownership of head and tail
  assign push    = tx ? (incr_stb & ~full) : (rx_msg_i & ~freset & ~full);
  assign pop     = tx ? (sent_i & ~freset & ~empty) : (incr_stb & ~empty);
  assign drained = tx & pop & ~push & (cnt == CNT_W'(1));

  mq_ptr_track #(.IDX_W(IDX_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .push_i     (push),
    .pop_i      (pop),
    .depth_m1_i (cfg.depth_m1),
    .head_o     (head),
    .tail_o     (tail),
    .count_o    (cnt),
    .empty_o    (empty),
    .full_o     (full)
  );

  mq_tx_ctrl u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (freset),
    .dir_tx_i     (tx),
    .wr_en_i      (wr_en_i),
    .req_wr_i     (wr_data_i[F_REQ]),
    .rtr_ev_i     (rtr_rx_i & cfg.rtr_en & ~freset),
    .drained_i    (drained),
    .sent_i       (sent_i & ~freset),
    .fail_i       (tx_fail_i & ~freset),
    .retry_en_i   (retry_glb_en_i),
    .retry_code_i (cfg.retry_code),
    .send_req_o   (send_req),
    .abort_o      (abort_o),
    .exhaust_o    (exhaust)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (clr || tx)               ovf_q <= 1'b0;
    else if (incr_stb)                ovf_q <= 1'b0;
    else if (rx_msg_i && full && !freset) ovf_q <= 1'b1;
  end

  // slot offsets: 0 = host side, 1 = engine side
  assign pay_b = pl_bytes(cfg.pl_code);
  logic [OFS_W-1:0] stride;
  logic [OFS_W-1:0] ofs [2];
  assign stride = OFS_W'(pay_b) + OFS_W'(HDR_BYTES);

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    logic [IDX_W-1:0] idx;
    assign idx    = ((g == 0) == tx) ? head : tail;
    assign ofs[g] = OFS_W'(idx) * stride;
  end

  assign host_ofs_o = ofs[0];
  assign eng_ofs_o  = ofs[1];

  // occupancy events by role
  assign depth   = CNT_W'(cfg.depth_m1) + CNT_W'(1);
  assign lvl_ev  = tx ? empty : full;
  assign half_ev = tx ? (cnt <= (depth >> 1)) : (cnt >= ((depth + CNT_W'(1)) >> 1));
  assign room_ev = tx ? ~full : ~empty;

  assign irq_exhaust_o = exhaust & cfg.ie[0];
  assign irq_ovf_o     = ovf_q   & cfg.ie[1];
  assign irq_lvl_o     = lvl_ev  & cfg.ie[2];
  assign irq_half_o    = half_ev & cfg.ie[3];
  assign irq_room_o    = room_ev & cfg.ie[4];
  assign irq_o = irq_exhaust_o | irq_ovf_o | irq_lvl_o | irq_half_o | irq_room_o;

  assign tx_pending_o    = send_req & tx & ~empty;
  assign payload_bytes_o = pay_b;
  assign prio_o          = cfg.prio;
  assign head_o          = head;
  assign tail_o          = tail;
  assign count_o         = cnt;
  assign empty_o         = empty;
  assign full_o          = full;

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[F_DEPTH +: DEPTH_W] = cfg.depth_m1;
    rd_data_o[F_PL +: 3]          = cfg.pl_code;
    rd_data_o[F_PRIO +: 5]        = cfg.prio;
    rd_data_o[F_RETRY +: 2]       = cfg.retry_code;
    rd_data_o[F_DIR]              = cfg.dir_tx;
    rd_data_o[F_RTR]              = cfg.rtr_en;
    rd_data_o[F_TS]               = cfg.ts_en;
    rd_data_o[F_IE +: 5]          = cfg.ie;
    rd_data_o[F_RST]              = freset;
    rd_data_o[F_REQ]              = send_req & tx;
  end
endmodule

// File: rtl/mq_checker.sv
module mq_checker
  import can_mq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic               rx_msg_i,
  input logic               sent_i,
  input logic [REG_W-1:0]   rd_data_o,
  input logic [DEPTH_W:0]   count_o,
  input logic               full_o,
  input logic               empty_o,
  input logic               abort_o,
  input logic               irq_ovf_o
);
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= ({1'b0, rd_data_o[F_DEPTH +: DEPTH_W]} + (DEPTH_W+1)'(1)));

  assert_full_not_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_freset_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[F_RST] && !wr_en_i) |=> (!rd_data_o[F_RST] && count_o == '0));

  assert_full_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[F_DIR] && full_o && wr_en_i && wr_data_i[F_INC] && !sent_i &&
     !rd_data_o[F_RST] && wr_data_i[F_DIR] && !wr_data_i[F_RST] &&
     wr_data_i[7:0] == rd_data_o[7:0]) |=> full_o);

  assert_abort_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(rd_data_o[F_REQ]));

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[F_DIR] && full_o && rx_msg_i && !rd_data_o[F_RST] &&
     rd_data_o[F_IE+1] && !wr_en_i) |=> irq_ovf_o);
endmodule

bind can_msg_queue mq_checker u_mq_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rx_msg_i  (rx_msg_i),
  .sent_i    (sent_i),
  .rd_data_o (rd_data_o),
  .count_o   (count_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .abort_o   (abort_o),
  .irq_ovf_o (irq_ovf_o)
);

// File: tb/can_msg_queue_tb_top.sv
module can_msg_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode = 3'b100;
  logic        rglb = 1'b0;
  logic        wr_en = 1'b0;
  logic [25:0] wr_data = '0;
  logic [25:0] rd_data;
  logic        sent = 1'b0, fail = 1'b0, rxm = 1'b0, rtr = 1'b0;
  logic [4:0]  head, tail, prio;
  logic [5:0]  count;
  logic        empty, full, txp, abrt;
  logic [11:0] hofs, eofs;
  logic [6:0]  pbytes;
  logic        i_exh, i_ovf, i_lvl, i_half, i_room, i_any;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  can_msg_queue dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .retry_glb_en_i(rglb),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .sent_i(sent), .tx_fail_i(fail), .rx_msg_i(rxm), .rtr_rx_i(rtr),
    .head_o(head), .tail_o(tail), .count_o(count), .empty_o(empty), .full_o(full),
    .tx_pending_o(txp), .abort_o(abrt), .host_ofs_o(hofs), .eng_ofs_o(eofs),
    .payload_bytes_o(pbytes), .prio_o(prio), .irq_exhaust_o(i_exh),
    .irq_ovf_o(i_ovf), .irq_lvl_o(i_lvl), .irq_half_o(i_half),
    .irq_room_o(i_room), .irq_o(i_any)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ie = {room, half, lvl, ovf, exhaust}
  function automatic logic [25:0] mk(input int dm1, input int pl, input int pr,
      input int rc, input bit txd, input bit rtren, input bit ie_all,
      input bit rst, input bit req, input bit inc);
    logic [25:0] w = '0;
    w[4:0]   = 5'(dm1);
    w[7:5]   = 3'(pl);
    w[12:8]  = 5'(pr);
    w[14:13] = 2'(rc);
    w[15]    = txd;
    w[16]    = rtren;
    w[22:18] = ie_all ? 5'h1f : 5'h00;
    w[23]    = rst;
    w[24]    = req;
    w[25]    = inc;
    return w;
  endfunction

  task automatic wr(input logic [25:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_sent();   sent = 1'b1; @(negedge clk); sent = 1'b0; endtask
  task automatic pulse_fail();   fail = 1'b1; @(negedge clk); fail = 1'b0; endtask
  task automatic pulse_rx();     rxm  = 1'b1; @(negedge clk); rxm  = 1'b0; endtask
  task automatic pulse_rtr();    rtr  = 1'b1; @(negedge clk); rtr  = 1'b0; endtask

  task automatic t_reset();
    chk("R6 reset bit after rst", int'(rd_data[23]), 1);
    chk("R1 empty after rst", int'(empty), 1);
    @(negedge clk);
    chk("R6 reset bit self-clears", int'(rd_data[23]), 0);
    chk("R6 count zero", int'(count), 0);
  endtask

  task automatic t_cfg_lock();
    mode = 3'b000;
    wr(mk(3, 6, 5, 3, 0, 0, 0, 0, 0, 0));
    chk("R3 depth locked", int'(rd_data[4:0]), 0);
    chk("R3 payload locked", int'(pbytes), 8);
    chk("R3 prio writable", int'(prio), 5);
    mode = 3'b100;
    wr(mk(3, 6, 5, 3, 0, 0, 0, 0, 0, 0));
    chk("R3 depth in config", int'(rd_data[4:0]), 3);
    chk("R2 code 6 is 48 bytes", int'(pbytes), 48);
    wr(mk(3, 2, 5, 3, 0, 0, 0, 0, 0, 0));
    chk("R2 code 2 is 16 bytes", int'(pbytes), 16);
  endtask

  task automatic t_tx_flow();
    logic [25:0] b = mk(3, 1, 0, 3, 1, 0, 1, 0, 0, 0);
    wr(b);
    chk("R11 tx empty irq", int'(i_lvl), 1);
    chk("R11 tx not-full irq", int'(i_room), 1);
    wr(b | 26'(1 << 25));
    wr(b | 26'(1 << 25));
    chk("R4 head after 2 incr", int'(head), 2);
    chk("R4 count 2", int'(count), 2);
    chk("R2 host ofs 2*(12+8)", int'(hofs), 40);
    chk("R13 half empty at 2 of 4", int'(i_half), 1);
    chk("R11 tx empty irq low", int'(i_lvl), 0);
    wr(b | 26'(1 << 25));
    chk("R13 not half empty at 3", int'(i_half), 0);
    wr(b | 26'(1 << 25));
    chk("R1 full at 4", int'(full), 1);
    chk("R11 not-full irq low", int'(i_room), 0);
    wr(b | 26'(1 << 25));
    chk("R4 incr ignored when full", int'(count), 4);
    wr(b | 26'(1 << 24));
    chk("R7 tx pending", int'(txp), 1);
    pulse_sent();
    chk("R4 tail after sent", int'(tail), 1);
    chk("R4 engine ofs", int'(eofs), 20);
    chk("R7 req held", int'(rd_data[24]), 1);
    pulse_sent(); pulse_sent();
    chk("R7 count 1", int'(count), 1);
    pulse_sent();
    chk("R7 req cleared on drain", int'(rd_data[24]), 0);
    chk("R7 no pending", int'(txp), 0);
  endtask

  task automatic t_abort();
    logic [25:0] b = mk(3, 1, 0, 3, 1, 0, 1, 0, 0, 0);
    wr(b | 26'(1 << 25));
    wr(b | 26'(1 << 24));
    chk("R8 req set", int'(rd_data[24]), 1);
    wr(b);
    chk("R8 abort pulse", int'(abrt), 1);
    chk("R8 req cleared", int'(rd_data[24]), 0);
    @(negedge clk);
    chk("R8 abort one cycle", int'(abrt), 0);
    b = mk(3, 1, 0, 3, 0, 0, 1, 0, 0, 0);
    wr(b | 26'(1 << 24));
    chk("R8 rx req reads 0", int'(rd_data[24]), 0);
    chk("R8 rx no pending", int'(txp), 0);
    wr(b);
    chk("R8 rx no abort", int'(abrt), 0);
  endtask

  task automatic t_rtr();
    wr(mk(3, 1, 0, 3, 1, 1, 1, 0, 0, 0));
    pulse_rtr();
    chk("R9 rtr sets req", int'(rd_data[24]), 1);
    wr(mk(3, 1, 0, 3, 1, 0, 1, 0, 0, 0));
    pulse_rtr();
    chk("R9 rtr ignored when disabled", int'(rd_data[24]), 0);
  endtask

  task automatic t_retry();
    rglb = 1'b1;
    wr(mk(3, 1, 0, 1, 1, 0, 1, 0, 1, 0));
    pulse_fail(); pulse_fail(); pulse_fail();
    chk("R10 code01 three fails ok", int'(i_exh), 0);
    chk("R10 code01 req held", int'(rd_data[24]), 1);
    pulse_fail();
    chk("R10 code01 exhausted", int'(i_exh), 1);
    chk("R10 exhaustion clears req", int'(rd_data[24]), 0);
    wr(mk(3, 1, 0, 0, 1, 0, 1, 0, 1, 0));
    chk("R10 new req clears flag", int'(i_exh), 0);
    pulse_fail();
    chk("R10 code00 first fail", int'(i_exh), 1);
    wr(mk(3, 1, 0, 3, 1, 0, 1, 0, 1, 0));
    for (int i = 0; i < 6; i++) pulse_fail();
    chk("R10 code11 unlimited", int'(i_exh), 0);
    rglb = 1'b0;
    wr(mk(3, 1, 0, 0, 1, 0, 1, 0, 1, 0));
    pulse_fail(); pulse_fail();
    chk("R10 global off unlimited", int'(i_exh), 0);
    wr(mk(3, 1, 0, 0, 1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_rx_flow();
    logic [25:0] b = mk(2, 7, 0, 3, 0, 0, 1, 0, 0, 0);
    wr(b);
    chk("R11 rx not-empty low", int'(i_room), 0);
    chk("R11 rx full low", int'(i_lvl), 0);
    pulse_rx();
    chk("R5 head after rx", int'(head), 1);
    chk("R11 rx not-empty irq", int'(i_room), 1);
    chk("R13 not half full at 1 of 3", int'(i_half), 0);
    pulse_rx();
    chk("R13 half full at 2 of 3", int'(i_half), 1);
    pulse_rx();
    chk("R11 rx full irq", int'(i_lvl), 1);
    chk("R11 any irq", int'(i_any), 1);
    chk("R12 no overflow yet", int'(i_ovf), 0);
    pulse_rx();
    chk("R12 overflow flag", int'(i_ovf), 1);
    chk("R12 count unchanged", int'(count), 3);
    wr(b | 26'(1 << 25));
    chk("R5 tail after incr", int'(tail), 1);
    chk("R2 rx host ofs 1*(64+8)", int'(hofs), 72);
    chk("R5 engine ofs wrapped head", int'(eofs), 0);
    chk("R12 incr clears overflow", int'(i_ovf), 0);
    wr(b | 26'(1 << 25));
    wr(b | 26'(1 << 25));
    chk("R5 empty", int'(count), 0);
    wr(b | 26'(1 << 25));
    chk("R5 incr ignored when empty", int'(tail), 0);
  endtask

  task automatic t_freset();
    logic [25:0] b = mk(2, 7, 0, 3, 0, 0, 1, 0, 0, 0);
    pulse_rx(); pulse_rx(); pulse_rx(); pulse_rx();
    wr(b | 26'(1 << 23));
    chk("R6 reset bit set by write", int'(rd_data[23]), 1);
    @(negedge clk);
    chk("R6 reset bit clears", int'(rd_data[23]), 0);
    chk("R6 count cleared", int'(count), 0);
    chk("R6 overflow cleared", int'(i_ovf), 0);
    chk("R6 head cleared", int'(head), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cfg_lock();
    t_tx_flow();
    t_abort();
    t_rtr();
    t_retry();
    t_rx_flow();
    t_freset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule